// File: doc/BRIEF.md
# MDIO Management Command Interface

This block is a management-bus master for Ethernet PHYs, driven by software through a single 32-bit command and status word. The host writes one word that holds the operation, the PHY address, the register address and the write data. The block then sends a Clause 22 management frame on the MDC clock and the shared MDIO data line. When the frame ends it sets a ready flag in the same word. For reads, it also places the returned data in that word.

The MDIO line is split into three signals: an output value, an output enable and an input. A read that gets no answer from the PHY sets an error flag, and software then treats the data field as invalid. Software polls the word until either the ready flag or the error flag is set.

Top module: `mdio_cmd_if`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A write on `reg_wr` while idle does three things. It clears the ready flag (bit 28) and the error flag (bit 30) on the next cycle. It starts a frame. It keeps the operation (bits 27:26), PHY address (25:21) and register address (20:16) readable in `reg_rdata`.
- R3: For the write operation (bits 27:26 = 01), the frame is 64 bits long, most significant bit first, with `mdio_oe` high for all 64 bits. In order, it carries:
  - 32 one-bits of preamble;
  - start bits 01;
  - the two operation bits;
  - the 5-bit PHY address;
  - the 5-bit register address;
  - turnaround bits 10;
  - the 16 bits of data from bits 15:0.
- R4: For the read operation (bits 27:26 = 10), the block drives the line for the first 46 bits of the frame. It releases `mdio_oe` from the first turnaround bit to the end of the frame. It shifts the 16 data bits into bits 15:0, most significant bit first, and then sets the ready flag with the error flag clear.
- R5: If the PHY does not drive the second turnaround bit low during a read, the transaction ends with both the error flag (bit 30) and the ready flag (bit 28) set.
- R6: MDC has a period of 2*HALF_DIV system clocks while a frame runs and is held low when idle. The block changes `mdio_o` only together with a falling edge of MDC. It samples `mdio_i` on the rising edge of MDC.
- R7: A write on `reg_wr` while a frame is running is ignored. The running frame, the fields shown in `reg_rdata` and the final result are those of the first command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word being written |
| reg_rdata | output | 32 | Command and status word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check these rules on every cycle:
- a start clears ready and error;
- error never appears without ready;
- MDC stays low when idle;
- `mdio_o` moves only on MDC falling edges;
- the output enable rises only at a frame start;
- a write while busy leaves the address and operation fields unchanged.

Only the bench scenarios can show the rest, using a PHY model that captures each frame. They show that each frame has the exact bit layout and release window. They show that read data is assembled in the right order, that a missing turnaround answer sets error, and that MDC has the right period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;
  localparam int F_DATA = 0;
  localparam int F_REG  = 16;
  localparam int F_PHY  = 21;
  localparam int F_OP   = 26;
  localparam int B_RDY  = 28;
  localparam int B_ERR  = 30;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc  = mdc_q;
  assign rise = tick & ~mdc_q;
  assign fall = tick & mdc_q;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        ta_err,
  output logic [15:0] rx_data
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);
  localparam logic [IW-1:0] TA1_IDX  = IW'(TA_FIRST);
  localparam logic [IW-1:0] TA2_IDX  = IW'(TA_SECOND);
  localparam logic [IW-1:0] D0_IDX   = IW'(DATA_FIRST);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic                  err_q, err_d;
  logic [15:0]           rx_q, rx_d;

  assign done = busy_q && fall && (idx_q == LAST_IDX);

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    err_d  = err_q;
    rx_d   = rx_q;
    if (start) begin
      sh_d   = {32'hFFFF_FFFF, 2'b01, op, phy, regad, 2'b10, wdata};
      idx_d  = '0;
      busy_d = 1'b1;
      rd_d   = (op == OP_READ);
      err_d  = 1'b0;
      rx_d   = '0;
    end else if (busy_q) begin
      if (rise && rd_q) begin
        if (idx_q == TA2_IDX && mdio_i) err_d = 1'b1;
        if (idx_q >= D0_IDX) rx_d = {rx_q[14:0], mdio_i};
      end
      if (fall) begin
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      err_q  <= err_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && !(rd_q && idx_q >= TA1_IDX);
  assign ta_err  = err_q;
  assign rx_data = rx_q;
endmodule

// File: rtl/mdio_cmd_if.sv
module mdio_cmd_if
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        busy, done, ta_err, rise, fall, start;
  logic [15:0] rx_data;
  logic [1:0]  op_q, op_d;
  logic [4:0]  phy_q, phy_d, reg_q, reg_d;
  logic [15:0] dat_q, dat_d;
  logic        rdy_q, rdy_d, err_q, err_d;

  assign start = reg_wr && !busy;

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op(reg_wdata[F_OP+:2]), .phy(reg_wdata[F_PHY+:5]),
    .regad(reg_wdata[F_REG+:5]), .wdata(reg_wdata[F_DATA+:16]),
    .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .ta_err(ta_err), .rx_data(rx_data)
  );

  always_comb begin
    op_d  = op_q;
    phy_d = phy_q;
    reg_d = reg_q;
    dat_d = dat_q;
    rdy_d = rdy_q;
    err_d = err_q;
    if (start) begin
      op_d  = reg_wdata[F_OP+:2];
      phy_d = reg_wdata[F_PHY+:5];
      reg_d = reg_wdata[F_REG+:5];
      dat_d = reg_wdata[F_DATA+:16];
      rdy_d = 1'b0;
      err_d = 1'b0;
    end else if (done) begin
      rdy_d = 1'b1;
      err_d = ta_err;
      if (op_q == OP_READ) dat_d = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      phy_q <= '0;
      reg_q <= '0;
      dat_q <= '0;
      rdy_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      op_q  <= op_d;
      phy_q <= phy_d;
      reg_q <= reg_d;
      dat_q <= dat_d;
      rdy_q <= rdy_d;
      err_q <= err_d;
    end
  end

  assign reg_rdata = {1'b0, err_q, 1'b0, rdy_q, op_q, phy_q, reg_q, dat_q};
endmodule

// File: rtl/mdio_cmd_if_chk.sv
module mdio_cmd_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [31:0] reg_rdata
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy) |=> (busy && !reg_rdata[28] && !reg_rdata[30]));

  a_r5_err_has_ready: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[30] |-> reg_rdata[28]);

  a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r6_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  a_r4_oe_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $rose(busy));

  a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(reg_rdata[27:16]));
endmodule

bind mdio_cmd_if mdio_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .busy(busy),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_rdata(reg_rdata)
);

// File: tb/tb_mdio_cmd_if.sv
module tb_mdio_cmd_if;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int NVEC       = 6;

  // {phy_responds, phy_read_data, command}
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 16'h0000, 4'h0, 2'b01, 5'd1,  5'd0,  16'h1140},
    {1'b0, 16'h0000, 4'h0, 2'b01, 5'd31, 5'd31, 16'hA5A5},
    {1'b1, 16'h796D, 4'h0, 2'b10, 5'd2,  5'd1,  16'h0000},
    {1'b1, 16'h8001, 4'h0, 2'b10, 5'd0,  5'd2,  16'hFFFF},
    {1'b0, 16'h0000, 4'h0, 2'b10, 5'd5,  5'd3,  16'h0000},
    {1'b0, 16'h0000, 4'h0, 2'b01, 5'd16, 5'd9,  16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_drv = 1'b0, phy_val = 1'b1, phy_resp = 1'b0;
  logic [15:0] phy_data = '0;
  logic [63:0] cap = '0, cap_oe = '0;
  int          pos = 0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  mdio_cmd_if #(.HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge mdc) begin
    cap    <= {cap[62:0], mdio_i};
    cap_oe <= {cap_oe[62:0], mdio_oe};
    pos    <= (pos == 63) ? 0 : pos + 1;
  end

  always @(negedge mdc) begin
    if (phy_resp && pos == 47) begin
      phy_drv <= 1'b1; phy_val <= 1'b0;
    end else if (phy_resp && pos >= 48) begin
      phy_drv <= 1'b1; phy_val <= phy_data[63-pos];
    end else begin
      phy_drv <= 1'b0; phy_val <= 1'b1;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] c);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = c;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!(reg_rdata[28] || reg_rdata[30]) && t < 2000) begin
      @(negedge clk); t++;
    end
  endtask

  function automatic logic [63:0] exp_frame(logic [31:0] c, logic resp, logic [15:0] pd);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, c[27:26], c[25:21], c[20:16], 2'b10, c[15:0]};
    if (c[27:26] == 2'b10)
      f[17:0] = resp ? {2'b10, pd} : {2'b11, 16'hFFFF};
    return f;
  endfunction

  function automatic logic [63:0] exp_oe(logic [31:0] c);
    return (c[27:26] == 2'b10) ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] c, a;
    realtime t0, t1;
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", 64'(reg_rdata), 64'h0);
    check("R1 mdc after reset", 64'(mdc), 64'h0);
    check("R1 oe after reset", 64'(mdio_oe), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      c = VEC[i][31:0];
      phy_resp = VEC[i][48];
      phy_data = VEC[i][47:32];
      send(c);
      check("R2 flags cleared at start", 64'({reg_rdata[30], reg_rdata[28]}), 64'h0);
      check("R2 fields kept", 64'(reg_rdata[27:16]), 64'(c[27:16]));
      wait_done();
      @(negedge clk);
      check(c[27:26] == 2'b10 ? "R4 read frame bits" : "R3 write frame bits",
            cap, exp_frame(c, phy_resp, phy_data));
      check(c[27:26] == 2'b10 ? "R4 read drive window" : "R3 write drive window",
            cap_oe, exp_oe(c));
      if (c[27:26] == 2'b10 && !phy_resp) begin
        check("R5 error and ready", 64'({reg_rdata[30], reg_rdata[28]}), 64'h3);
      end else begin
        check("R4 ready no error", 64'({reg_rdata[30], reg_rdata[28]}), 64'h1);
        check("R4 data field", 64'(reg_rdata[15:0]),
              64'(c[27:26] == 2'b10 ? phy_data : c[15:0]));
      end
      check("R6 mdc low idle", 64'(mdc), 64'h0);
    end

    // MDC period and a write while busy
    a = {4'h0, 2'b10, 5'd7, 5'd4, 16'h0000};
    phy_resp = 1'b1; phy_data = 16'h3C5A;
    send(a);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check("R6 mdc period", 64'(int'((t1 - t0) / CLK_PERIOD)), 64'(2*HALF_DIV));
    repeat (60) @(negedge clk);
    send({4'h0, 2'b01, 5'd9, 5'd9, 16'hDEAD});
    check("R7 fields unchanged", 64'(reg_rdata[27:16]), 64'(a[27:16]));
    wait_done();
    @(negedge clk);
    check("R7 frame of first command", cap, exp_frame(a, 1'b1, 16'h3C5A));
    check("R7 result of first command", 64'(reg_rdata), 64'({4'h1, a[27:16], 16'h3C5A}));
    repeat (20) @(negedge clk);
    check("R7 no second frame", 64'({mdc, mdio_oe, reg_rdata[28]}), 64'h1);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rdata after second reset", 64'(reg_rdata), 64'h0);
    finish_run();
  end
endmodule